// File: doc/BRIEF.md
# FSK Carrier-Detect Qualifier

This block takes a per-sample flag saying that energy is present in the FSK receive band and turns it into a clean, active-low carrier-detect output. The downstream serial data interface uses the matching active-high carrier-valid signal as its gate. While carrier-valid is low, that interface ignores the demodulator.

Onset is qualified digitally. The sample clock is divided into 1 ms ticks. A tick counts as active when the flag was high for at least half of its samples. Carrier detect asserts once enough of the most recent ticks in a sliding window are active. After that, a hold timer keeps the output asserted through short gaps in the flag. The timer reloads on every sample where the flag is high, and carrier detect is released only after 8 ms with no activity. On release the persistence window is emptied, so a new carrier must qualify again from scratch.

The FSK-enable input and the power-down input each force the output inactive and clear every timer. Reset does the same.

Top module: `fsk_cd_qual`

## Requirements
- R1: Out of reset, cd_n_o is 1 and carrier_valid_o is 0.
- R2: With raw_i held high while the block is enabled, cd_n_o goes low within 25 ticks. It stays high until at least ON_MIN - 1 ticks of enabled time have passed.
- R3: A tick is active when raw_i was high on at least ceil(TICK_DIV/2) of its TICK_DIV samples. With TICK_DIV = 10, a steady pattern of 5 high samples in every 10 qualifies, and a pattern of 4 in every 10 never does.
- R4: Carrier detect asserts only when at least ON_MIN of the last WIN_TICKS ticks are active (defaults 9 of 10). A steady pattern of 15 high samples in every 40 never asserts it.
- R5: While carrier detect is asserted, a gap in raw_i of at most HOLD_TICKS*TICK_DIV cycles leaves cd_n_o low on every cycle. A sample with raw_i high reloads the hold timer.
- R6: After raw_i stays low for HOLD_TICKS*TICK_DIV + 1 cycles, cd_n_o returns to 1. The window is then emptied, so onset needs a fresh qualification period.
- R7: fsk_en_i low drives cd_n_o to 1 at the next clock and clears all timers. No raw_i activity asserts carrier detect while fsk_en_i stays low.
- R8: pwdn_i high drives cd_n_o to 1 at the next clock and clears all timers. No raw_i activity asserts carrier detect while pwdn_i stays high.
- R9: carrier_valid_o is always the complement of cd_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsk_en_i | input | 1 | FSK path enable, active high |
| pwdn_i | input | 1 | Power-down, active high |
| raw_i | input | 1 | Per-sample in-band energy flag |
| cd_n_o | output | 1 | Carrier detect, active low |
| carrier_valid_o | output | 1 | Gate for the serial data interface, active high |

## Verification
Some behaviours are checked by the assertions on every cycle:
- enable and power-down force the output high at the next edge;
- the output stays low on any cycle where the flag is high;
- release never comes before a full hold period of quiet samples;
- onset never comes before the minimum qualification time, and always comes within the 25-tick bound while the flag is held high;
- the two outputs stay complementary.

Other behaviours can only be shown by the bench scenarios, because each depends on a particular input pattern:
- the per-tick vote threshold at exactly half the samples;
- rejection of a sparse flag that never fills the window;
- a dropout just shorter than the hold period compared with one just longer;
- the emptied window forcing a full requalification after release, re-enable or wake-up.

// File: rtl/fsk_cd_pkg.sv
package fsk_cd_pkg;
  typedef enum logic {
    CD_IDLE   = 1'b0,
    CD_ACTIVE = 1'b1
  } cd_state_e;

  // Sample clock at 3.579545 MHz gives about 3580 cycles per 1 ms tick
  localparam int unsigned DEF_TICK_DIV   = 3580;
  localparam int unsigned DEF_WIN_TICKS  = 10;
  localparam int unsigned DEF_ON_MIN     = 9;
  localparam int unsigned DEF_HOLD_TICKS = 8;
endpackage

// File: rtl/cd_tick_vote.sv
module cd_tick_vote #(
  parameter int unsigned TICK_DIV = 3580
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic raw_i,
  output logic tick_o,
  output logic vote_o
);
  localparam int unsigned CW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned HW       = $clog2(TICK_DIV + 1);
  localparam int unsigned VOTE_MIN = (TICK_DIV + 1) / 2;

  logic [CW-1:0] cnt_q;
  logic [HW-1:0] hi_q;
  logic [HW-1:0] hi_next;
  logic          last;
  logic          tick_q, vote_q;

  assign last    = (cnt_q == CW'(TICK_DIV - 1));
  assign hi_next = hi_q + HW'(raw_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hi_q   <= '0;
      tick_q <= 1'b0;
      vote_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      hi_q   <= '0;
      tick_q <= 1'b0;
      vote_q <= 1'b0;
    end else begin
      tick_q <= last;
      vote_q <= last && (hi_next >= HW'(VOTE_MIN));
      if (last) begin
        cnt_q <= '0;
        hi_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        hi_q  <= hi_next;
      end
    end
  end

  assign tick_o = tick_q;
  assign vote_o = vote_q;
endmodule

// File: rtl/cd_onset_window.sv
module cd_onset_window #(
  parameter int unsigned WIN_TICKS = 10,
  parameter int unsigned ON_MIN    = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic vote_i,
  output logic qual_o
);
  localparam int unsigned NW = $clog2(WIN_TICKS + 1);

  logic [WIN_TICKS-1:0] hist_q;
  logic [NW-1:0]        ones;

  for (genvar k = 0; k < WIN_TICKS; k++) begin : g_stage
    logic din;
    if (k == 0) begin : g_head
      assign din = vote_i;
    end else begin : g_body
      assign din = hist_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hist_q[k] <= 1'b0;
      else if (clr_i)  hist_q[k] <= 1'b0;
      else if (tick_i) hist_q[k] <= din;
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < WIN_TICKS; i++) ones = ones + NW'(hist_q[i]);
  end

  assign qual_o = (ones >= NW'(ON_MIN));
endmodule

// File: rtl/cd_hold_timer.sv
module cd_hold_timer #(
  parameter int unsigned HOLD_CYC = 28640
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic raw_i,
  output logic expired_o
);
  localparam int unsigned TW = $clog2(HOLD_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (raw_i)          cnt_q <= TW'(HOLD_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/fsk_cd_qual.sv
module fsk_cd_qual
  import fsk_cd_pkg::*;
#(
  parameter int unsigned TICK_DIV   = DEF_TICK_DIV,
  parameter int unsigned WIN_TICKS  = DEF_WIN_TICKS,
  parameter int unsigned ON_MIN     = DEF_ON_MIN,
  parameter int unsigned HOLD_TICKS = DEF_HOLD_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsk_en_i,
  input  logic pwdn_i,
  input  logic raw_i,
  output logic cd_n_o,
  output logic carrier_valid_o
);
  localparam int unsigned HOLD_CYC = HOLD_TICKS * TICK_DIV;

  cd_state_e state_q, state_d;
  logic      off;
  logic      tick, vote, qual, expired;
  logic      release_now;

  assign off = !fsk_en_i || pwdn_i;

  cd_tick_vote #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (off),
    .raw_i  (raw_i),
    .tick_o (tick),
    .vote_o (vote)
  );

  cd_onset_window #(.WIN_TICKS(WIN_TICKS), .ON_MIN(ON_MIN)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (off || release_now),
    .tick_i (tick),
    .vote_i (vote),
    .qual_o (qual)
  );

  cd_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (off),
    .raw_i     (raw_i),
    .expired_o (expired)
  );

  assign release_now = (state_q == CD_ACTIVE) && expired && !raw_i && !off;

  always_comb begin
    state_d = state_q;
    if (off)                                     state_d = CD_IDLE;
    else if (state_q == CD_IDLE && qual)         state_d = CD_ACTIVE;
    else if (release_now)                        state_d = CD_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CD_IDLE;
    else         state_q <= state_d;
  end

  assign cd_n_o          = (state_q != CD_ACTIVE);
  assign carrier_valid_o = (state_q == CD_ACTIVE);
endmodule

// File: rtl/cd_qual_checker.sv
module cd_qual_checker #(
  parameter int unsigned TICK_DIV    = 3580,
  parameter int unsigned ON_MIN      = 9,
  parameter int unsigned HOLD_TICKS  = 8,
  parameter int unsigned ONSET_TICKS = 25
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fsk_en_i,
  input logic pwdn_i,
  input logic raw_i,
  input logic cd_n_o,
  input logic carrier_valid_o
);
  localparam int unsigned HOLD_CYC  = HOLD_TICKS * TICK_DIV;
  localparam int unsigned MIN_ON    = (ON_MIN - 1) * TICK_DIV;
  localparam int unsigned MAX_ON    = ONSET_TICKS * TICK_DIV;
  localparam int unsigned CAP       = MAX_ON + HOLD_CYC + 2;

  logic on;
  int unsigned quiet_q, en_q, run_q;

  assign on = fsk_en_i && !pwdn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q <= 0;
      en_q    <= 0;
      run_q   <= 0;
    end else begin
      quiet_q <= (!on || raw_i) ? 0 : ((quiet_q < CAP) ? quiet_q + 1 : quiet_q);
      en_q    <= !on ? 0 : ((en_q < CAP) ? en_q + 1 : en_q);
      run_q   <= (on && raw_i && cd_n_o) ? ((run_q < CAP) ? run_q + 1 : run_q) : 0;
    end
  end

  assert_disable_forces_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsk_en_i |=> cd_n_o);

  assert_pwdn_forces_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwdn_i |=> cd_n_o);

  assert_valid_complement_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_valid_o != cd_n_o);

  assert_hold_on_activity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cd_n_o && raw_i && on) |=> !cd_n_o);

  assert_release_after_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cd_n_o) && $past(on)) |-> (quiet_q >= HOLD_CYC));

  assert_onset_not_early_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cd_n_o) |-> (en_q >= MIN_ON));

  assert_onset_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= MAX_ON);
endmodule

bind fsk_cd_qual cd_qual_checker #(
  .TICK_DIV   (TICK_DIV),
  .ON_MIN     (ON_MIN),
  .HOLD_TICKS (HOLD_TICKS),
  .ONSET_TICKS(25)
) u_cd_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fsk_en_i       (fsk_en_i),
  .pwdn_i         (pwdn_i),
  .raw_i          (raw_i),
  .cd_n_o         (cd_n_o),
  .carrier_valid_o(carrier_valid_o)
);

// File: tb/sim_fsk_cd_qual.sv
`timescale 1ns/1ps
module sim_fsk_cd_qual;
  localparam int TD   = 10;
  localparam int HOLD = 8 * TD;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fsk_en = 1'b0;
  logic pwdn = 1'b0;
  logic raw = 1'b0;
  logic cd_n, valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  always #10 clk = ~clk;

  fsk_cd_qual #(.TICK_DIV(TD), .WIN_TICKS(10), .ON_MIN(9), .HOLD_TICKS(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fsk_en_i(fsk_en), .pwdn_i(pwdn),
    .raw_i(raw), .cd_n_o(cd_n), .carrier_valid_o(valid)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc_cnt);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  // Clear state by a one-cycle disable, then enable with given raw level
  task automatic restart(input logic lvl);
    fsk_en = 1'b0; pwdn = 1'b0; raw = 1'b0;
    cyc(2);
    fsk_en = 1'b1; raw = lvl;
  endtask

  task automatic t_reset();
    cyc(2);
    chk(cd_n, 1'b1, "R1 cd_n in reset");
    chk(valid, 1'b0, "R1 valid in reset");
    rst_ni = 1'b1;
    cyc(3);
    chk(cd_n, 1'b1, "R1 cd_n after reset");
    chk(valid, 1'b0, "R1 valid after reset");
  endtask

  task automatic t_onset();
    restart(1'b1);
    cyc(70);
    chk(cd_n, 1'b1, "R2 no onset before minimum");
    cyc(180);
    chk(cd_n, 1'b0, "R2 onset within 25 ticks");
    chk(valid, 1'b1, "R9 valid while active");
  endtask

  task automatic t_dropout();
    logic ok = 1'b1;
    raw = 1'b0;
    for (int i = 0; i < HOLD - 2; i++) begin
      cyc(1);
      if (cd_n !== 1'b0) ok = 1'b0;
    end
    raw = 1'b1;
    cyc(10);
    chk(ok, 1'b1, "R5 short dropout held");
    chk(cd_n, 1'b0, "R5 still active after dropout");
  endtask

  task automatic t_release();
    raw = 1'b0;
    cyc(HOLD - 5);
    chk(cd_n, 1'b0, "R6 active before hold expiry");
    cyc(10);
    chk(cd_n, 1'b1, "R6 released after hold");
    chk(valid, 1'b0, "R9 valid after release");
    raw = 1'b1;
    cyc(70);
    chk(cd_n, 1'b1, "R6 window emptied on release");
    cyc(180);
    chk(cd_n, 1'b0, "R6 requalified");
  endtask

  task automatic t_vote();
    logic ok = 1'b1;
    restart(1'b0);
    for (int p = 0; p < 30; p++) begin
      for (int s = 0; s < TD; s++) begin
        raw = (s < 4);
        cyc(1);
        if (cd_n !== 1'b1) ok = 1'b0;
      end
    end
    chk(ok, 1'b1, "R3 4 of 10 samples never qualifies");
    for (int p = 0; p < 30; p++) begin
      for (int s = 0; s < TD; s++) begin
        raw = (s < 5);
        cyc(1);
      end
    end
    chk(cd_n, 1'b0, "R3 5 of 10 samples qualifies");
  endtask

  task automatic t_window();
    logic ok = 1'b1;
    restart(1'b0);
    for (int p = 0; p < 12; p++) begin
      for (int s = 0; s < 40; s++) begin
        raw = (s < 15);
        cyc(1);
        if (cd_n !== 1'b1) ok = 1'b0;
      end
    end
    chk(ok, 1'b1, "R4 sparse activity never fills window");
  endtask

  task automatic t_enable();
    logic ok = 1'b1;
    restart(1'b1);
    cyc(250);
    chk(cd_n, 1'b0, "R7 active before disable");
    fsk_en = 1'b0;
    cyc(1);
    chk(cd_n, 1'b1, "R7 disable forces idle");
    for (int i = 0; i < 300; i++) begin
      cyc(1);
      if (cd_n !== 1'b1) ok = 1'b0;
    end
    chk(ok, 1'b1, "R7 raw ignored while disabled");
    fsk_en = 1'b1;
    cyc(70);
    chk(cd_n, 1'b1, "R7 timers cleared by disable");
    cyc(180);
    chk(cd_n, 1'b0, "R7 requalified after enable");
  endtask

  task automatic t_pwdn();
    logic ok = 1'b1;
    pwdn = 1'b1;
    cyc(1);
    chk(cd_n, 1'b1, "R8 power-down forces idle");
    chk(valid, 1'b0, "R9 valid in power-down");
    for (int i = 0; i < 300; i++) begin
      cyc(1);
      if (cd_n !== 1'b1) ok = 1'b0;
    end
    chk(ok, 1'b1, "R8 raw ignored in power-down");
    pwdn = 1'b0;
    cyc(70);
    chk(cd_n, 1'b1, "R8 timers cleared by power-down");
    cyc(180);
    chk(cd_n, 1'b0, "R8 requalified after wake");
  endtask

  initial begin
    t_reset();
    t_onset();
    t_dropout();
    t_release();
    t_vote();
    t_window();
    t_enable();
    t_pwdn();
    raw = 1'b0;
    cyc(5);
    finish_run();
  end
endmodule